// File: doc/BRIEF.md
# Sleep-Depth Selection and Wake Controller

This controller sits beside a processor core and turns its wait-for-interrupt or wait-for-event request into one of three sleep depths. Two control bits select the depth. With the deep flag clear, only the core clock stops ("nap"). With the deep flag set and the depth-select bit clear, the core and peripheral clocks both stop ("halt"). With both bits set, the regulators switch off and only the retention domain stays powered ("deep"). The depth is taken from these bits in the cycle that the sleep request arrives.

Leaving nap or halt resumes execution. The peripheral clocks restart one cycle before the core clock, and a single-cycle wake pulse goes to the core. In halt, a fast-wake option, captured at entry, keeps the low-frequency clock running. Without it, an oscillator start-up wait of `SLOW_WAKE` cycles comes before the restart. The deep state cannot resume: an enabled wake event there raises a system reset request for `RST_HOLD` cycles, after which the controller returns to run.

The reset pin and a vector of fault inputs (supply monitor, comparator, charge pump, oscillator) force the same reset request from any state. Each wake and reset input passes through a two-flop synchronizer.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: While the synchronous reset is held, and in the first cycle after it, the controller is in run. Core clock, peripheral clock, low-frequency keep-alive, regulator and retention enables are 1, and the wake pulse and reset request are 0.
- R2: In run, a sleep request with the deep flag clear enters nap one cycle later: core clock 0, while peripheral clock, keep-alive, regulator and retention stay 1.
- R3: In nap, a pending interrupt wakes the core one cycle after it is seen, and so does an enabled, synchronized wake event. The core clock returns to 1 together with the wake pulse.
- R4: A sleep request with the deep flag set and depth-select clear enters halt: both clocks 0, regulator and retention 1. A pending interrupt does not wake from halt.
- R5: In halt, the keep-alive output equals the fast-wake enable captured at entry. With fast wake, the controller spends one restart cycle after the wake is seen and then runs. Without it, SLOW_WAKE oscillator-wait cycles (clocks 0, keep-alive 1) come before that restart cycle.
- R6: When the core clock turns on, the peripheral clock was already on in the previous cycle. Leaving halt, the restart cycle has the peripheral clock 1 and the core clock 0.
- R7: A sleep request with the deep flag and depth-select both set enters deep: regulator 0, both clocks 0, retention 1, keep-alive 1.
- R8: In deep, an enabled wake event asserts the reset request for RST_HOLD (at least 4) consecutive cycles with no wake pulse. The controller then runs with the core clock on.
- R9: A pulse on the reset pin or on any fault input starts the same reset request sequence from any state, including run and deep.
- R10: Wake and reset inputs pass through two flops. A change applied before clock edge k takes effect on the outputs at edge k+2, never earlier.
- R11: A wake source whose mask bit is 0 has no effect in any sleep state.
- R12: A sleep request is refused, and the controller stays in run, while an interrupt is pending or an enabled synchronized wake event is active.
- R13: The wake pulse is high for exactly one cycle per resume, and only while the core clock is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Single-cycle strobe from the core's sleep instruction |
| deep_flag | input | 1 | Selects a clock-halting sleep when set |
| depth_sel | input | 1 | With deep_flag set, chooses deep (1) over halt (0) |
| fast_wake_en | input | 1 | Keeps the low-frequency clock alive in halt |
| wake_mask | input | NW | Per-source wake enable |
| wake_evt | input | NW | Asynchronous wake event lines |
| irq_pend | input | 1 | Core interrupt pending (synchronous) |
| rst_pin | input | 1 | External reset pin request, active high |
| fault_evt | input | NF | Supply, comparator, charge-pump and oscillator fault lines |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| lf_clk_keep | output | 1 | Low-frequency clock keep-alive |
| reg_en | output | 1 | Regulator enable |
| ret_pwr_en | output | 1 | Retention domain power enable |
| wake_pulse | output | 1 | One-cycle resume pulse to the core |
| sys_rst_req | output | 1 | System reset request |

## Verification
The assertions assume that the reset request is followed by a real system reset only outside this block. They also assume that reset-pin and fault lines are pulses, not levels that stay active past the hold window. The stimulus releases every reset source one cycle after raising it and clears each wake line before the next sleep. Sleep requests are always single-cycle strobes given from run, and the sweep covers every depth, fast-wake setting, source and mask state.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_NAP     = 3'd1,
    ST_HALT    = 3'd2,
    ST_OSCWAIT = 3'd3,
    ST_RESTART = 3'd4,
    ST_DEEP    = 3'd5,
    ST_RSTHOLD = 3'd6
  } lpm_state_t;

  typedef struct packed {
    logic core;
    logic periph;
    logic lf;
    logic reg_on;
    logic ret;
  } lpm_gates_t;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        s1[i] <= 1'b0;
        q[i]  <= 1'b0;
      end else begin
        s1[i] <= d[i];
        q[i]  <= s1[i];
      end
    end
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int SLOW_WAKE = 8,
  parameter int RST_HOLD  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req,
  input  logic       deep_flag,
  input  logic       depth_sel,
  input  logic       fast_wake_en,
  input  logic       irq_pend,
  input  logic       wake_hit,
  input  logic       rst_hit,
  output lpm_state_t state_nxt,
  output logic       fw_nxt,
  output logic       pulse_nxt
);
  localparam int MAXC = (SLOW_WAKE > RST_HOLD) ? SLOW_WAKE : RST_HOLD;
  localparam int CW   = $clog2(MAXC + 1);

  lpm_state_t    state;
  logic          fw_q;
  logic [CW-1:0] cnt;

  always_comb begin
    state_nxt = state;
    if (rst_hit && state != ST_RSTHOLD) begin
      state_nxt = ST_RSTHOLD;
    end else begin
      case (state)
        ST_RUN:
          if (sleep_req && !(irq_pend || wake_hit))
            state_nxt = !deep_flag ? ST_NAP : (depth_sel ? ST_DEEP : ST_HALT);
        ST_NAP:
          if (irq_pend || wake_hit) state_nxt = ST_RUN;
        ST_HALT:
          if (wake_hit) state_nxt = fw_q ? ST_RESTART : ST_OSCWAIT;
        ST_OSCWAIT:
          if (cnt == CW'(SLOW_WAKE - 1)) state_nxt = ST_RESTART;
        ST_RESTART:
          state_nxt = ST_RUN;
        ST_DEEP:
          if (wake_hit) state_nxt = ST_RSTHOLD;
        ST_RSTHOLD:
          if (cnt == CW'(RST_HOLD - 1)) state_nxt = ST_RUN;
        default:
          state_nxt = ST_RUN;
      endcase
    end
  end

  assign fw_nxt    = (state == ST_RUN && state_nxt == ST_HALT) ? fast_wake_en : fw_q;
  assign pulse_nxt = (state == ST_NAP || state == ST_RESTART) && state_nxt == ST_RUN;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RUN;
      fw_q  <= 1'b0;
      cnt   <= '0;
    end else begin
      state <= state_nxt;
      fw_q  <= fw_nxt;
      cnt   <= (state_nxt != state) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lpm_outreg.sv
module lpm_outreg
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lpm_state_t state_nxt,
  input  logic       fw_nxt,
  input  logic       pulse_nxt,
  output lpm_gates_t gates,
  output logic       wake_pulse,
  output logic       sys_rst_req
);
  lpm_gates_t g_nxt;

  always_comb begin
    g_nxt = '{core: 1'b0, periph: 1'b0, lf: 1'b1, reg_on: 1'b1, ret: 1'b1};
    case (state_nxt)
      ST_RUN:     g_nxt.core   = 1'b1;
      ST_HALT:    g_nxt.lf     = fw_nxt;
      ST_DEEP:    g_nxt.reg_on = 1'b0;
      ST_RESTART: g_nxt.periph = 1'b1;
      ST_RSTHOLD: g_nxt.periph = 1'b1;
      ST_OSCWAIT: g_nxt.lf     = 1'b1;
      default:    g_nxt.periph = 1'b1;
    endcase
    if (state_nxt == ST_RUN || state_nxt == ST_NAP) g_nxt.periph = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gates       <= '{core: 1'b1, periph: 1'b1, lf: 1'b1, reg_on: 1'b1, ret: 1'b1};
      wake_pulse  <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      gates       <= g_nxt;
      wake_pulse  <= pulse_nxt;
      sys_rst_req <= (state_nxt == ST_RSTHOLD);
    end
  end
endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
  import lpm_pkg::*;
#(
  parameter int NW        = 7,
  parameter int NF        = 4,
  parameter int SLOW_WAKE = 8,
  parameter int RST_HOLD  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_req,
  input  logic          deep_flag,
  input  logic          depth_sel,
  input  logic          fast_wake_en,
  input  logic [NW-1:0] wake_mask,
  input  logic [NW-1:0] wake_evt,
  input  logic          irq_pend,
  input  logic          rst_pin,
  input  logic [NF-1:0] fault_evt,
  output logic          core_clk_en,
  output logic          periph_clk_en,
  output logic          lf_clk_keep,
  output logic          reg_en,
  output logic          ret_pwr_en,
  output logic          wake_pulse,
  output logic          sys_rst_req
);
  localparam int NR = NF + 1;

  logic [NW-1:0] wake_s;
  logic [NR-1:0] rsrc_s;
  lpm_state_t    state_nxt;
  logic          fw_nxt, pulse_nxt;
  lpm_gates_t    gates;

  lpm_sync #(.W(NW)) u_wsync (.clk(clk), .rst(rst), .d(wake_evt), .q(wake_s));
  lpm_sync #(.W(NR)) u_rsync (.clk(clk), .rst(rst), .d({fault_evt, rst_pin}), .q(rsrc_s));

  lpm_fsm #(.SLOW_WAKE(SLOW_WAKE), .RST_HOLD(RST_HOLD)) u_fsm (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .deep_flag(deep_flag),
    .depth_sel(depth_sel), .fast_wake_en(fast_wake_en), .irq_pend(irq_pend),
    .wake_hit(|(wake_s & wake_mask)), .rst_hit(|rsrc_s),
    .state_nxt(state_nxt), .fw_nxt(fw_nxt), .pulse_nxt(pulse_nxt)
  );

  lpm_outreg u_out (
    .clk(clk), .rst(rst), .state_nxt(state_nxt), .fw_nxt(fw_nxt),
    .pulse_nxt(pulse_nxt), .gates(gates), .wake_pulse(wake_pulse),
    .sys_rst_req(sys_rst_req)
  );

  assign core_clk_en   = gates.core;
  assign periph_clk_en = gates.periph;
  assign lf_clk_keep   = gates.lf;
  assign reg_en        = gates.reg_on;
  assign ret_pwr_en    = gates.ret;
endmodule

// File: rtl/lpm_entry_ctrl_chk.sv
module lpm_entry_ctrl_chk #(
  parameter int RST_HOLD = 4
) (
  input logic clk,
  input logic rst,
  input logic core_clk_en,
  input logic periph_clk_en,
  input logic reg_en,
  input logic ret_pwr_en,
  input logic wake_pulse,
  input logic sys_rst_req
);
  logic [2:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (!sys_rst_req) hi_cnt <= '0;
    else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
  end

  assert_periph_first_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(core_clk_en) |-> $past(periph_clk_en));

  assert_core_needs_periph_R6: assert property (@(posedge clk) disable iff (rst)
    core_clk_en |-> periph_clk_en);

  assert_pulse_single_R13: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  assert_pulse_core_on_R13: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> core_clk_en);

  assert_deep_retains_R7: assert property (@(posedge clk) disable iff (rst)
    !reg_en |-> (ret_pwr_en && !core_clk_en && !periph_clk_en));

  assert_reset_no_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> !wake_pulse);

  assert_reset_len_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_req) |-> (hi_cnt >= 3'd4));
endmodule

bind lpm_entry_ctrl lpm_entry_ctrl_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk(clk), .rst(rst), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
  .reg_en(reg_en), .ret_pwr_en(ret_pwr_en), .wake_pulse(wake_pulse),
  .sys_rst_req(sys_rst_req)
);

// File: tb/lpm_entry_ctrl_tb.sv
module lpm_entry_ctrl_tb;
  localparam int NW   = 4;
  localparam int NF   = 2;
  localparam int SLOW = 8;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 0, deep_flag = 0, depth_sel = 0, fast_wake_en = 0;
  logic [NW-1:0] wake_mask = '0, wake_evt = '0;
  logic irq_pend = 0, rst_pin = 0;
  logic [NF-1:0] fault_evt = '0;
  logic core_clk_en, periph_clk_en, lf_clk_keep, reg_en, ret_pwr_en, wake_pulse, sys_rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lpm_entry_ctrl #(.NW(NW), .NF(NF), .SLOW_WAKE(SLOW), .RST_HOLD(HOLD)) u_dut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .deep_flag(deep_flag),
    .depth_sel(depth_sel), .fast_wake_en(fast_wake_en), .wake_mask(wake_mask),
    .wake_evt(wake_evt), .irq_pend(irq_pend), .rst_pin(rst_pin), .fault_evt(fault_evt),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .lf_clk_keep(lf_clk_keep),
    .reg_en(reg_en), .ret_pwr_en(ret_pwr_en), .wake_pulse(wake_pulse),
    .sys_rst_req(sys_rst_req)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // compares {core, periph, lf, reg, ret, pulse, rstreq}
  task automatic chk(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {core_clk_en, periph_clk_en, lf_clk_keep, reg_en, ret_pwr_en, wake_pulse, sys_rst_req};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  localparam logic [6:0] RUN_O  = 7'b11111_0_0;
  localparam logic [6:0] RUN_P  = 7'b11111_1_0;
  localparam logic [6:0] NAP_O  = 7'b01111_0_0;
  localparam logic [6:0] DEEP_O = 7'b00101_0_0;
  localparam logic [6:0] OSCW_O = 7'b00111_0_0;
  localparam logic [6:0] RSTR_O = 7'b01111_0_0;
  localparam logic [6:0] HOLD_O = 7'b01111_0_1;

  function automatic logic [6:0] sleep_exp(input logic d, input logic m, input logic fw);
    if (!d) return NAP_O;
    if (m) return DEEP_O;
    return {2'b00, fw, 2'b11, 2'b00};
  endfunction

  task automatic reset_seq(input string req);
    rst_pin = 1'b1; cyc(1); rst_pin = 1'b0;
    cyc(2);
    chk(req, HOLD_O);
    cyc(HOLD - 1);
    chk({req, " hold length"}, HOLD_O);
    cyc(1);
    chk({req, " back to run"}, RUN_O);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    chk("R1 reset state", RUN_O);
    cyc(1);
    chk("R1 after reset", RUN_O);

    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 2; m++)
        for (int fw = 0; fw < 2; fw++)
          for (int src = 0; src < NW; src++)
            for (int en = 0; en < 2; en++) begin
              logic [6:0] se;
              se = sleep_exp(d[0], m[0], fw[0]);
              wake_mask = en ? '1 : ~(NW'(1) << src);
              deep_flag = d[0]; depth_sel = m[0]; fast_wake_en = fw[0];
              sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
              chk("R2 R4 R7 sleep entry", se);
              wake_evt[src] = 1'b1;
              cyc(2);
              chk("R10 no effect before sync", se);
              cyc(1);
              if (en) begin
                if (!d) begin
                  chk("R3 nap wake event", RUN_P);
                  cyc(1); chk("R13 pulse one cycle", RUN_O);
                end else if (m) begin
                  chk("R8 deep wake to reset", HOLD_O);
                  cyc(HOLD - 1); chk("R8 reset held", HOLD_O);
                  cyc(1); chk("R8 run after reset", RUN_O);
                end else begin
                  if (!fw) begin
                    chk("R5 oscillator wait", OSCW_O);
                    cyc(SLOW - 1); chk("R5 oscillator wait end", OSCW_O);
                    cyc(1);
                  end
                  chk("R6 restart periph first", RSTR_O);
                  cyc(1); chk("R6 core after periph", RUN_P);
                  cyc(1); chk("R13 pulse one cycle", RUN_O);
                end
              end else begin
                chk("R11 masked source ignored", se);
                wake_evt[src] = 1'b0;
                irq_pend = 1'b1; cyc(1);
                if (!d) begin
                  irq_pend = 1'b0;
                  chk("R3 nap irq wake", RUN_P);
                  cyc(1); chk("R13 pulse one cycle", RUN_O);
                end else begin
                  cyc(1); irq_pend = 1'b0;
                  chk("R4 irq ignored when clocks halted", se);
                  reset_seq("R9 reset pin from sleep");
                end
              end
              wake_evt = '0;
              cyc(3);
            end

    // R12: refusal with pending wake or interrupt
    deep_flag = 1'b1; depth_sel = 1'b1; wake_mask = '1;
    wake_evt[1] = 1'b1; cyc(3);
    sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
    chk("R12 refused on pending wake", RUN_O);
    wake_evt = '0; cyc(3);
    irq_pend = 1'b1; sleep_req = 1'b1; cyc(1); sleep_req = 1'b0; irq_pend = 1'b0;
    chk("R12 refused on pending irq", RUN_O);
    cyc(1);

    // R9: fault inputs from run and from deep
    for (int f = 0; f < NF; f++) begin
      fault_evt[f] = 1'b1; cyc(1); fault_evt[f] = 1'b0;
      cyc(1); chk("R9 R10 fault not yet seen", RUN_O);
      cyc(1); chk("R9 fault from run", HOLD_O);
      cyc(HOLD); chk("R9 run after fault", RUN_O);
      sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
      chk("R7 deep entry", DEEP_O);
      fault_evt[f] = 1'b1; cyc(1); fault_evt[f] = 1'b0;
      cyc(2); chk("R9 fault from deep", HOLD_O);
      cyc(HOLD); chk("R9 run after deep fault", RUN_O);
    end
    reset_seq("R9 reset pin from run");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule